// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block sits after a Reed-Solomon decoder that works on 12-bit symbols. A page of 1367 symbols is packed, most significant bit first, into a byte-wide buffer. The first 2048 bytes of that buffer are the data area and the bytes after them are the spare area. The decoder hands the block (symbol position, 12-bit error pattern) pairs on a valid/ready stream. For each pair, the block finds the one or two bytes that the symbol covers and XORs the pattern into them. Each byte is updated with a read-modify-write on a RAM port that has one cycle of read latency.

The buffer is addressed linearly. The data area is at addresses 0 to 2047 and spare byte k is at address 2048+k. Because of this, the symbol that crosses from the data area into the spare area needs no special path. Symbol 0 is the exception. It carries four leading bits that are not stored, so only its low eight pattern bits reach memory.

A done strobe closes a page. The decoder marks it either as a success, in which case the number of symbols applied for the page is reported and added to a running total, or as a failure, in which case a separate failure total is incremented.

Top module: `rs_fix_apply`

## Requirements
- R1: For an odd position p, byte floor(3p/2) is XORed with pattern bits 11:4. Byte floor(3p/2)+1 is XORed with pattern bits 3:0 placed in its bits 7:4.
- R2: For an even position p above 0, byte 3p/2-1 is XORed with pattern bits 11:8 placed in its bits 3:0. Byte 3p/2 is XORed with pattern bits 7:0.
- R3: Position 0 changes only byte 0, which is XORed with pattern bits 7:0. Pattern bits 11:8 have no effect.
- R4: Addresses are linear across both areas, with spare byte k at address 2048+k. Position 1365 touches byte 2047 and spare byte 0. Position 1366 touches spare bytes 0 and 1.
- R5: A pair whose position is 1367 or higher is accepted but dropped. It causes no RAM access and is not counted.
- R6: At most 4 pairs are applied per page. Any further pair before the done strobe is accepted and dropped.
- R7: Each byte update is a read cycle followed directly by a write cycle to the same address. in_ready stays low for the whole update: 4 cycles for a two-byte symbol and 2 cycles for position 0.
- R8: Updates are serialized. Two pairs that touch the same byte both take effect, and their XORs accumulate.
- R9: A done strobe with done_fail low is taken while in_ready is high. In the next cycle it produces a one-cycle rpt_valid with rpt_fixed equal to the number of pairs applied for the page, and adds that number to fixed_total.
- R10: A done strobe with done_fail high raises rpt_fail, adds 1 to fail_total and leaves fixed_total unchanged.
- R11: After reset, in_ready is high, no RAM access is made, rpt_valid is low and both totals are zero.
- R12: A pair and a done strobe taken in the same cycle belong to the same page. The pair is counted in that report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Correction pair valid |
| in_pos | input | 12 | Symbol position |
| in_pat | input | 12 | Error pattern |
| in_ready | output | 1 | Block idle; pair and done strobe accepted |
| done_valid | input | 1 | End-of-page strobe |
| done_fail | input | 1 | Page could not be decoded |
| ram_rd | output | 1 | RAM read strobe; data returns next cycle |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 12 | Linear byte address |
| ram_wdata | output | 8 | Write data |
| ram_rdata | input | 8 | Read data |
| rpt_valid | output | 1 | Page report pulse |
| rpt_fixed | output | 3 | Pairs applied in the reported page |
| rpt_fail | output | 1 | Reported page failed |
| fixed_total | output | 16 | Running total of applied pairs |
| fail_total | output | 16 | Running total of failed pages |

## Verification
The block is driven with odd and even positions using distinct nibble patterns. These show whether the high, middle and low nibbles land in the right bytes and in the right halves of those bytes. Position 0, positions 1365 and 1366, and out-of-range positions separate the phantom-bit rule, the crossing into the spare area, and the drop rule from the general mapping. Two pairs that share a byte check that the XORs accumulate. A run of five pairs checks the per-page limit. After every scenario the whole buffer is compared against a bit-level model, so stray writes to other bytes are also caught.

// File: rtl/rs_fix_apply.sv
`timescale 1ns/1ps
module rs_fix_apply #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int CW_SYMS     = 1367,
  parameter int MAX_ERR     = 4,
  parameter int TW          = 16,
  localparam int AW = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int NW = $clog2(MAX_ERR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [11:0]   in_pos,
  input  logic [11:0]   in_pat,
  output logic          in_ready,
  input  logic          done_valid,
  input  logic          done_fail,
  output logic          ram_rd,
  output logic          ram_wr,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          rpt_valid,
  output logic [NW-1:0] rpt_fixed,
  output logic          rpt_fail,
  output logic [TW-1:0] fixed_total,
  output logic [TW-1:0] fail_total
);
  localparam logic [11:0]   POS_LIM = 12'(CW_SYMS);
  localparam logic [NW-1:0] CAP     = NW'(MAX_ERR);
  localparam logic [AW-1:0] MEM_LIM = AW'(DATA_BYTES + SPARE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_RD_A, S_WR_A, S_RD_B, S_WR_B} st_t;
  st_t state;

  logic [AW-1:0] a_q, b_q;
  logic [7:0]    ma_q, mb_q;
  logic [NW-1:0] page_cnt;

  logic [13:0]   x3;
  logic [AW-1:0] base;
  logic          odd, lead, take, close;

  assign x3    = {1'b0, in_pos, 1'b0} + {2'b00, in_pos};
  assign base  = x3[AW:1];
  assign odd   = in_pos[0];
  assign lead  = (in_pos == 12'd0);
  assign in_ready = (state == S_IDLE);
  assign take  = in_valid && in_ready && (in_pos < POS_LIM) && (page_cnt < CAP);
  assign close = done_valid && in_ready;

  assign ram_rd    = (state == S_RD_A) || (state == S_RD_B);
  assign ram_wr    = (state == S_WR_A) || (state == S_WR_B);
  assign ram_addr  = (state == S_RD_A || state == S_WR_A) ? a_q : b_q;
  assign ram_wdata = ram_rdata ^ ((state == S_WR_A) ? ma_q : mb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      a_q <= '0; b_q <= '0; ma_q <= '0; mb_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          a_q  <= odd ? base : base - AW'(1);
          b_q  <= odd ? base + AW'(1) : base;
          ma_q <= odd ? in_pat[11:4] : {4'h0, in_pat[11:8]};
          mb_q <= odd ? {in_pat[3:0], 4'h0} : in_pat[7:0];
          state <= lead ? S_RD_B : S_RD_A;
        end
        S_RD_A: state <= S_WR_A;
        S_WR_A: state <= S_RD_B;
        S_RD_B: state <= S_WR_B;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_cnt <= '0; rpt_valid <= 1'b0; rpt_fixed <= '0; rpt_fail <= 1'b0;
      fixed_total <= '0; fail_total <= '0;
    end else begin
      rpt_valid <= close;
      if (close) begin
        page_cnt  <= '0;
        rpt_fixed <= page_cnt + {{(NW-1){1'b0}}, take};
        rpt_fail  <= done_fail;
        if (done_fail) fail_total <= fail_total + TW'(1);
        else fixed_total <= fixed_total + TW'(page_cnt) + TW'(take);
      end else if (take) begin
        page_cnt <= page_cnt + NW'(1);
      end
    end
  end

  a_r7_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> ram_wr);
  a_r7_wr_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> ($past(ram_rd) && $past(ram_addr) == ram_addr));
  a_r8_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_wr) |-> !in_ready);
  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
    page_cnt <= CAP);
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_wr) |-> ram_addr < MEM_LIM);
  a_r10_fail_on_report: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_total != $past(fail_total)) |-> (rpt_valid && rpt_fail));
  a_r9_total_on_report: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_total != $past(fixed_total)) |-> (rpt_valid && !rpt_fail));
endmodule

// File: tb/sim_rs_fix_apply.sv
`timescale 1ns/1ps
module sim_rs_fix_apply;
  localparam int MEMSZ = 2112;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, done_valid = 1'b0, done_fail = 1'b0;
  logic [11:0] in_pos = '0, in_pat = '0;
  logic in_ready, ram_rd, ram_wr, rpt_valid, rpt_fail;
  logic [11:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic [2:0] rpt_fixed;
  logic [15:0] fixed_total, fail_total;

  logic [7:0] mem [0:MEMSZ-1];
  logic [7:0] expm [0:MEMSZ-1];
  int checks = 0, errors = 0;
  int exp_fixed = 0, exp_fail = 0;

  always #2 clk = ~clk;

  rs_fix_apply u0 (.clk, .rst_n, .in_valid, .in_pos, .in_pat, .in_ready,
    .done_valid, .done_fail, .ram_rd, .ram_wr, .ram_addr, .ram_wdata, .ram_rdata,
    .rpt_valid, .rpt_fixed, .rpt_fail, .fixed_total, .fail_total);

  always_ff @(posedge clk) begin
    if (ram_wr) mem[ram_addr] <= ram_wdata;
    if (ram_rd) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-level model: symbol p occupies stream bits 12p-4 .. 12p+7, msb first
  task automatic model(input int p, input logic [11:0] pat);
    for (int k = 0; k < 12; k++) begin
      int g = 12*p - 4 + k;
      if (g >= 0) expm[g/8][7 - (g%8)] = expm[g/8][7 - (g%8)] ^ pat[11-k];
    end
  endtask

  task automatic send(input int p, input logic [11:0] pat, output int busy);
    @(negedge clk);
    in_valid = 1'b1; in_pos = 12'(p); in_pat = pat;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    busy = 0;
    while (!in_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic close_page(input bit f, input int nfix, input string req);
    @(negedge clk);
    done_valid = 1'b1; done_fail = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    done_valid = 1'b0; done_fail = 1'b0;
    if (f) exp_fail++; else exp_fixed += nfix;
    chk(rpt_valid == 1'b1, {req, " rpt_valid"}, int'(rpt_valid), 1);
    chk(rpt_fixed == 3'(nfix) && rpt_fail == f, {req, " rpt fixed/fail"},
        int'({rpt_fail, rpt_fixed}), int'({f, 3'(nfix)}));
    chk(fixed_total == 16'(exp_fixed) && fail_total == 16'(exp_fail), {req, " totals"},
        int'({fixed_total, fail_total}), int'({16'(exp_fixed), 16'(exp_fail)}));
    @(negedge clk);
    chk(rpt_valid == 1'b0, {req, " rpt pulse width"}, int'(rpt_valid), 0);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    for (int i = 0; i < MEMSZ; i++) if (bad < 0 && mem[i] !== expm[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, $sformatf("%s byte %0d", req, bad), int'(mem[bad]), int'(expm[bad]));
  endtask

  task automatic t_reset;
    chk(in_ready && !ram_rd && !ram_wr && !rpt_valid, "R11 idle outputs",
        int'({in_ready, ram_rd, ram_wr, rpt_valid}), 8);
    chk(fixed_total == 0 && fail_total == 0, "R11 totals", int'({fixed_total, fail_total}), 0);
  endtask

  task automatic t_odd_even;
    int b;
    send(1, 12'hABC, b); model(1, 12'hABC);
    chk(b == 4, "R7 two-byte busy cycles", b, 4);
    compare("R1 odd mapping");
    chk(mem[1] == (8'(1*7+3) ^ 8'hAB), "R1 byte1", int'(mem[1]), int'(8'(10) ^ 8'hAB));
    send(6, 12'h5A3, b); model(6, 12'h5A3);
    compare("R2 even mapping");
    chk(mem[9] == (8'(9*7+3) ^ 8'hA3), "R2 low byte", int'(mem[9]), int'(8'(66) ^ 8'hA3));
    close_page(1'b0, 2, "R9 success page");
  endtask

  task automatic t_zero;
    int b;
    send(0, 12'hF12, b); model(0, 12'hF12);
    chk(b == 2, "R7 single-byte busy cycles", b, 2);
    chk(mem[0] == (8'd3 ^ 8'h12), "R3 byte0", int'(mem[0]), int'(8'd3 ^ 8'h12));
    compare("R3 phantom bits ignored");
    close_page(1'b0, 1, "R9 zero page");
  endtask

  task automatic t_straddle;
    int b;
    send(1365, 12'h9C6, b); model(1365, 12'h9C6);
    send(1366, 12'h3E7, b); model(1366, 12'h3E7);
    compare("R4 straddle and spare");
    chk(mem[2048] == expm[2048], "R4 spare byte 0", int'(mem[2048]), int'(expm[2048]));
    close_page(1'b0, 2, "R9 straddle page");
  endtask

  task automatic t_same_byte;
    int b;
    send(3, 12'h0F0, b); model(3, 12'h0F0);
    send(4, 12'hF0F, b); model(4, 12'hF0F);
    send(3, 12'h00F, b); model(3, 12'h00F);
    compare("R8 accumulated XOR");
    close_page(1'b0, 3, "R8 page");
  endtask

  task automatic t_range_cap;
    int b;
    send(1367, 12'hFFF, b);
    chk(b == 0, "R5 no access busy", b, 0);
    send(4095, 12'hFFF, b);
    compare("R5 out of range dropped");
    close_page(1'b0, 0, "R5 page count");
    for (int i = 0; i < 4; i++) begin send(20 + i, 12'h111, b); model(20 + i, 12'h111); end
    send(30, 12'h777, b);
    chk(b == 0, "R6 fifth dropped busy", b, 0);
    compare("R6 cap");
    close_page(1'b0, 4, "R6 page count");
  endtask

  task automatic t_fail;
    int b;
    send(40, 12'h321, b); model(40, 12'h321);
    close_page(1'b1, 1, "R10 failed page");
    compare("R10 memory");
  endtask

  task automatic t_same_cycle;
    int b;
    @(negedge clk);
    in_valid = 1'b1; in_pos = 12'd50; in_pat = 12'h456; done_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; done_valid = 1'b0;
    model(50, 12'h456);
    exp_fixed += 1;
    chk(rpt_valid && rpt_fixed == 3'd1, "R12 joint report", int'(rpt_fixed), 1);
    chk(fixed_total == 16'(exp_fixed), "R12 total", int'(fixed_total), exp_fixed);
    b = 0;
    while (!in_ready) begin b++; @(negedge clk); end
    compare("R12 memory");
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) begin mem[i] = 8'(i*7+3); expm[i] = 8'(i*7+3); end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_odd_even;
    t_zero;
    t_straddle;
    t_same_byte;
    t_range_cap;
    t_fail;
    t_same_cycle;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule